// File: doc/BRIEF.md
# Streaming Pixel Histogram Engine

This block counts how often each 8-bit intensity value appears in a streamed image frame. It builds one 256-bin table per colour channel, so a single-channel stream gives one table and a three-channel stream gives three. Pixels arrive over a valid/ready handshake. Each accepted beat carries either one pixel or eight pixels, and that count is fixed when the block is built. When all pixels of the frame have been taken in, the block emits every bin count on an output stream. It then pulses a completion flag.

A frame starts with a `start` pulse while the block is idle. The row and column counts are sampled at that moment and capped at the build-time maxima. All bin storage is then swept to zero before any pixel is accepted. In eight-pixel mode each lane owns a private table for every channel, so equal values within one beat never compete for a memory port. The lane tables are summed bin by bin while the result is read out. A two-stage read-modify-write pipeline in each table forwards its pending count when the same bin is hit again. This keeps repeated values exact at full rate.

Top module: `hist_engine`

## Requirements
- R1: During reset and directly after it, `pix_ready`, `out_valid` and `done` are all low.
- R2: A `start` pulse in the idle state begins a zeroing sweep. For 256 clocks after the `start` edge, `pix_ready` is low, and it goes high on the clock that follows.
- R3: Rows above MAX_ROWS are treated as MAX_ROWS, and columns above MAX_COLS as MAX_COLS. The frame is complete after rows*(cols/LANES) accepted beats, and `pix_ready` is low from the clock after the last accepted beat.
- R4: Within `pix_data`, the byte for lane l and channel c sits at bit offset (l*CHANNELS+c)*8. Its unsigned value selects the bin that is incremented in that channel's table.
- R5: All lanes of one beat are counted, including lanes that carry the same value in the same channel.
- R6: A bin hit on consecutive beats, in the same lane or in several lanes, gains exactly one count per hit.
- R7: After the frame, CHANNELS*256 words appear with `out_valid` high on consecutive clocks. They run channel 0 bins 0 to 255, then channel 1, then channel 2, each word being the count zero-extended to 32 bits.
- R8: Every count, including the sum over lanes, stops at 2^CNT_W-1 instead of wrapping. The default CNT_W=32 gives 0xFFFFFFFF.
- R9: `done` is high for exactly one clock, on the clock after the last output word.
- R10: Every frame's counts begin at zero, whatever the previous frame held.
- R11: A `start` pulse while a frame is being cleared or accepted has no effect on that frame's pixels, timing or results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame (sampled when idle) |
| cfg_rows | input | 16 | Frame height in rows |
| cfg_cols | input | 16 | Frame width in pixels |
| pix_valid | input | 1 | Pixel beat valid |
| pix_data | input | LANES*CHANNELS*8 | Pixel beat, lane-major then channel |
| pix_ready | output | 1 | Engine can accept a beat |
| out_valid | output | 1 | Histogram word valid |
| out_data | output | 32 | Histogram bin count |
| done | output | 1 | One-clock pulse after the last word |

## Verification
The hardest case to reach from the ports is a table in one lane that receives the same bin on back-to-back beats while the previous increment is still in its write stage. The same frame also has to push the lane sum past its saturation limit. The bench is built with narrow 8-bit counters and sends a full-size frame whose every byte equals one value, which reaches both at once. Random-gap frames and `start` pulses injected during the clear and accept phases then confirm that the forwarding and the clear sweep leave no residue in the following frame.

// File: rtl/hist_pkg.sv
package hist_pkg;
  localparam int BIN_W = 8;
  localparam int NBINS = 256;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_RUN,
    ST_DRAIN,
    ST_DUMP,
    ST_FIN
  } hist_state_e;
endpackage

// File: rtl/hist_bank.sv
module hist_bank
  import hist_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_en,
  input  logic [BIN_W-1:0] clr_addr,
  input  logic             in_vld,
  input  logic [BIN_W-1:0] in_idx,
  input  logic [BIN_W-1:0] rd_addr,
  output logic [CNT_W-1:0] rd_data
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] mem [NBINS];
  logic             s1_vld, s2_vld;
  logic [BIN_W-1:0] s1_idx, s2_idx;
  logic [CNT_W-1:0] s2_val;
  logic [CNT_W-1:0] cur_cnt, nxt_cnt;

  // read stage: take the in-flight write when it targets the same bin
  always_comb begin
    cur_cnt = (s2_vld && (s2_idx == s1_idx)) ? s2_val : mem[s1_idx];
    nxt_cnt = (cur_cnt == CMAX) ? CMAX : cur_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s2_vld <= 1'b0;
    end else begin
      s1_vld <= in_vld;
      s2_vld <= s1_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_idx <= '0;
    end else if (in_vld) begin
      s1_idx <= in_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_idx <= '0;
      s2_val <= '0;
    end else if (s1_vld) begin
      s2_idx <= s1_idx;
      s2_val <= nxt_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (clr_en) begin
      mem[clr_addr] <= '0;
    end else if (s2_vld) begin
      mem[s2_idx] <= s2_val;
    end
  end

  assign rd_data = mem[rd_addr];

  // R8
  sat_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s2_vld |-> (s2_val != '0));

  // R6
  fwd_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && s2_vld && (s1_idx == s2_idx)) |=>
      ((s2_val == $past(s2_val) + 1'b1) || ($past(s2_val) == CMAX)));

  // R2
  clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> (!in_vld && !s2_vld));
endmodule

// File: rtl/hist_ctrl.sv
module hist_ctrl
  import hist_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int CHANNELS = 1,
  parameter int MAX_ROWS = 2160,
  parameter int MAX_COLS = 3840,
  localparam int OUT_N   = CHANNELS * NBINS,
  localparam int OUT_W   = $clog2(OUT_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [15:0]      cfg_rows,
  input  logic [15:0]      cfg_cols,
  input  logic             beat_fire,
  output hist_state_e      state,
  output logic             clr_en,
  output logic [BIN_W-1:0] clr_addr,
  output logic             dump_en,
  output logic [OUT_W-1:0] dump_idx,
  output logic             fin
);
  localparam int MAX_BEATS = MAX_ROWS * (MAX_COLS / LANES);
  localparam int BEAT_W    = $clog2(MAX_BEATS + 1);
  localparam int CW        = (BEAT_W > OUT_W) ? BEAT_W : OUT_W;

  hist_state_e      st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [BEAT_W-1:0] beats_q, beats_d;
  logic [31:0]      rows_c, cols_c, beats_calc;

  always_comb begin
    rows_c     = (32'(cfg_rows) > 32'(MAX_ROWS)) ? 32'(MAX_ROWS) : 32'(cfg_rows);
    cols_c     = (32'(cfg_cols) > 32'(MAX_COLS)) ? 32'(MAX_COLS) : 32'(cfg_cols);
    beats_calc = rows_c * (cols_c / 32'(LANES));
  end

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    beats_d = beats_q;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d    = ST_CLEAR;
        cnt_d   = '0;
        beats_d = BEAT_W'(beats_calc);
      end
      ST_CLEAR: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CW'(NBINS - 1)) begin
          cnt_d = '0;
          st_d  = (beats_q == '0) ? ST_DRAIN : ST_RUN;
        end
      end
      ST_RUN: if (beat_fire) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CW'(beats_q - 1'b1)) begin
          cnt_d = '0;
          st_d  = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CW'(1)) begin
          cnt_d = '0;
          st_d  = ST_DUMP;
        end
      end
      ST_DUMP: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CW'(OUT_N - 1)) begin
          cnt_d = '0;
          st_d  = ST_FIN;
        end
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      beats_q <= '0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      beats_q <= beats_d;
    end
  end

  assign state    = st_q;
  assign clr_en   = (st_q == ST_CLEAR);
  assign clr_addr = cnt_q[BIN_W-1:0];
  assign dump_en  = (st_q == ST_DUMP);
  assign dump_idx = cnt_q[OUT_W-1:0];
  assign fin      = (st_q == ST_FIN);
endmodule

// File: rtl/hist_engine.sv
module hist_engine
  import hist_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int CHANNELS = 1,
  parameter int MAX_ROWS = 2160,
  parameter int MAX_COLS = 3840,
  parameter int CNT_W    = 32,
  localparam int PIX_W   = LANES * CHANNELS * BIN_W,
  localparam int OUT_N   = CHANNELS * NBINS,
  localparam int OUT_W   = $clog2(OUT_N),
  localparam int CH_W    = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [15:0]      cfg_rows,
  input  logic [15:0]      cfg_cols,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  output logic             pix_ready,
  output logic             out_valid,
  output logic [31:0]      out_data,
  output logic             done
);
  logic             rst_s1, rst_sync;
  hist_state_e      state;
  logic             clr_en, dump_en, fin, beat_fire;
  logic [BIN_W-1:0] clr_addr;
  logic [OUT_W-1:0] dump_idx;
  logic [CH_W-1:0]  ch_sel;
  logic [CNT_W-1:0] rd_w [CHANNELS][LANES];
  logic [CNT_W:0]   acc;
  logic             out_valid_q, done_q;
  logic [CNT_W-1:0] out_cnt_q;

  // reset asserts at once, leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1   <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_s1   <= 1'b1;
      rst_sync <= rst_s1;
    end
  end

  hist_ctrl #(
    .LANES(LANES), .CHANNELS(CHANNELS), .MAX_ROWS(MAX_ROWS), .MAX_COLS(MAX_COLS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_sync), .start(start), .cfg_rows(cfg_rows),
    .cfg_cols(cfg_cols), .beat_fire(beat_fire), .state(state),
    .clr_en(clr_en), .clr_addr(clr_addr), .dump_en(dump_en),
    .dump_idx(dump_idx), .fin(fin)
  );

  assign pix_ready = (state == ST_RUN);
  assign beat_fire = pix_valid && pix_ready;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      hist_bank #(.CNT_W(CNT_W)) u_bank (
        .clk(clk), .rst_n(rst_sync), .clr_en(clr_en), .clr_addr(clr_addr),
        .in_vld(beat_fire),
        .in_idx(pix_data[(l*CHANNELS+c)*BIN_W +: BIN_W]),
        .rd_addr(dump_idx[BIN_W-1:0]),
        .rd_data(rd_w[c][l])
      );
    end
  end

  // lane sum for the selected bin, clamped after every addition
  always_comb begin
    ch_sel = CH_W'(dump_idx >> BIN_W);
    acc    = '0;
    for (int l = 0; l < LANES; l++) begin
      acc = acc + {1'b0, rd_w[ch_sel][l]};
      if (acc[CNT_W]) acc = {1'b0, {CNT_W{1'b1}}};
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      out_valid_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      out_valid_q <= dump_en;
      done_q      <= fin;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      out_cnt_q <= '0;
    end else if (dump_en) begin
      out_cnt_q <= acc[CNT_W-1:0];
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = 32'(out_cnt_q);
  assign done      = done_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    done |=> !done);

  // R9
  done_after_word_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    $rose(done) |-> ($past(out_valid) && !out_valid));

  // R7
  ready_out_excl_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    out_valid |-> !pix_ready);

  // R2
  clear_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    clr_en |-> !pix_ready);
endmodule

// File: tb/hist_engine_test.sv
module hist_engine_test;
  localparam int LANES = 8, CH = 3, MR = 8, MC = 64, CW = 8;
  localparam int PW = LANES * CH * 8;
  localparam int CMAX = (1 << CW) - 1;

  logic clk, rst_n, start, pix_valid, pix_ready, out_valid, done;
  logic [15:0] cfg_rows, cfg_cols;
  logic [PW-1:0] pix_data;
  logic [31:0] out_data;

  int checks = 0, fails = 0, cyc = 0;
  int phase = 0;             // 0 idle, 1 clear, 2 run, 3 output
  int cl_left = 0, beats_left = 0;
  int hist [CH][256];
  int expq [$];
  int words = 0, dones = 0;
  bit prev_ov = 0;
  string tag;

  hist_engine #(.LANES(LANES), .CHANNELS(CH), .MAX_ROWS(MR), .MAX_COLS(MC),
                .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_rows(cfg_rows),
    .cfg_cols(cfg_cols), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_ready(pix_ready), .out_valid(out_valid), .out_data(out_data),
    .done(done));

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
      summary();
    end
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: check outputs, apply inputs, advance model for the next edge
  task automatic step(bit s, bit v, logic [PW-1:0] d, int r, int c);
    @(negedge clk);
    chk(pix_ready == (phase == 2), (phase == 1) ? "R2" : "R3",
        pix_ready, phase == 2);
    if (out_valid) begin
      words++;
      if (expq.size() == 0) chk(0, {"R7 ", tag}, out_data, -1);
      else begin
        int e = expq.pop_front();
        chk(out_data == 32'(e), {"R7 ", tag}, out_data, e);
      end
    end
    if (done) begin
      dones++;
      chk(prev_ov && expq.size() == 0 && phase == 3, "R9", expq.size(), 0);
      phase = 0;
    end
    prev_ov = out_valid;
    start = s; pix_valid = v; pix_data = d;
    cfg_rows = 16'(r); cfg_cols = 16'(c);
    if (phase == 0 && s) begin
      int rr = (r > MR) ? MR : r;
      int cc = (c > MC) ? MC : c;
      phase = 1; cl_left = 256; beats_left = rr * (cc / LANES);
      foreach (hist[i, j]) hist[i][j] = 0;
    end else if (phase == 1) begin
      cl_left--;
      if (cl_left == 0) phase = 2;
    end else if (phase == 2 && v) begin
      for (int l = 0; l < LANES; l++)
        for (int k = 0; k < CH; k++)
          hist[k][d[(l*CH+k)*8 +: 8]]++;
      beats_left--;
      if (beats_left == 0) begin
        phase = 3;
        for (int k = 0; k < CH; k++)
          for (int b = 0; b < 256; b++)
            expq.push_back(hist[k][b] > CMAX ? CMAX : hist[k][b]);
      end
    end
  endtask

  // mode 0 random, 1 all bytes 7, 2 random with gaps and stray starts, 3 extremes
  task automatic frame(int r, int c, int mode, string t);
    int guard = 0;
    tag = t; words = 0; dones = 0;
    step(1, 0, '0, r, c);
    while (phase != 0 && guard < 5000) begin
      logic [PW-1:0] d;
      bit v = 1, s = 0;
      for (int i = 0; i < LANES * CH; i++)
        d[i*8 +: 8] = (mode == 1) ? 8'd7 :
                      (mode == 3) ? (($urandom % 2) ? 8'd255 : 8'd0) :
                      8'($urandom);
      if (mode == 2) begin
        v = ($urandom % 2) == 1;
        s = (phase == 1 || phase == 2) && ($urandom % 4 == 0); // R11
      end
      step(s, v, d, s ? 1 : r, s ? 8 : c);
      guard++;
    end
    chk(words == CH * 256, {"R7 word count ", t}, words, CH * 256);
    chk(dones == 1, "R9 done count", dones, 1);
  endtask

  initial begin
    rst_n = 0; start = 0; pix_valid = 0; pix_data = '0;
    cfg_rows = 0; cfg_cols = 0;
    repeat (3) begin
      @(negedge clk);
      chk(!pix_ready && !out_valid && !done, "R1", {pix_ready, out_valid, done}, 0);
    end
    rst_n = 1;
    repeat (3) begin
      @(negedge clk);
      chk(!pix_ready && !out_valid && !done, "R1", {pix_ready, out_valid, done}, 0);
    end
    frame(2, 16, 0, "R4 random bytes");
    frame(8, 64, 1, "R5 R6 R8 equal bytes");
    frame(20, 200, 3, "R3 clamped size");
    frame(3, 24, 2, "R10 R11 gaps and stray start");
    frame(1, 8, 0, "R10 single beat");
    summary();
  end
endmodule